// File: doc/BRIEF.md
# USB Host Frame Timer

This block paces a USB host's frames. A down-counter of remaining PHY clocks runs from a programmed interval to zero. In the cycle in which it shows zero, the block raises a start-of-frame strobe, and on the next clock edge it reloads from the interval input. A frame number advances with every start-of-frame and wraps within a 14-bit range by default.

Software may ask for the frame number to restart. The request is held until the next start-of-frame, and the frame that begins there is numbered zero. The block also shows the parity of the current frame number. For each periodic channel it gives an eligibility bit, which is set when the frame parity the channel asks for matches the current frame. Packet generation and the PHY are outside this block.

Top module: `usb_sof_timer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the remaining count takes the value of `interval_i`, the frame number becomes 0 and no start-of-frame is shown.
- R2: On each clock edge where the remaining count is non-zero, it drops by exactly one.
- R3: On a clock edge where the remaining count is zero, it reloads from `interval_i`, so one frame lasts `interval_i`+1 clocks.
- R4: `sof_o` is high exactly in the cycles where the remaining count is zero. With a non-zero interval it is therefore a single-cycle pulse. With an interval of zero it stays high every cycle.
- R5: The frame number increases by one on the edge that ends a start-of-frame cycle and does not change on any other edge.
- R6: The frame number goes from 0x3FFF (all ones at the default 14 bits) back to 0.
- R7: A one-cycle pulse on `frnum_clr_i` leaves the frame number unchanged until the next start-of-frame, and that start-of-frame yields frame number 0. This also holds when the pulse falls in the start-of-frame cycle itself. The request is used up after one start-of-frame.
- R8: A change to `interval_i` in the middle of a frame does not alter the countdown in progress. The new value is used only at the next reload.
- R9: `odd_frame_o` equals bit 0 of the frame number. `chan_elig_o[i]` is 1 when `odd_sel_i[i]` matches it, where 0 selects even frames and 1 selects odd frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PHY clock |
| rst_n | input | 1 | Synchronous reset, active low |
| interval_i | input | IVL_W (16) | Frame interval in clocks, minus one |
| frnum_clr_i | input | 1 | Request that the next frame be numbered 0 |
| odd_sel_i | input | NUM_CH (4) | Per-channel frame parity choice, 1 = odd |
| remain_o | output | IVL_W (16) | Clocks remaining in the current frame |
| frnum_o | output | FNUM_W (14) | Current frame number |
| odd_frame_o | output | 1 | Current frame number is odd |
| sof_o | output | 1 | Start-of-frame strobe |
| chan_elig_o | output | NUM_CH (4) | Per-channel eligibility in this frame |

## Verification
The checker watches every cycle for four things: the countdown step, the reload from the interval, the single-cycle width of the strobe, and the frame number rules for hold, increment, wrap and forced zero. It also checks the per-channel parity match in every cycle. Some behaviour only the bench scenarios can show. One is the whole frame length seen at the ports. Another is that a request to restart the frame number stays pending through a frame and is spent after a single use. Others are the mid-frame interval change and the full wrap of the frame number after 16384 frames.

// File: rtl/usb_sof_pkg.sv
package usb_sof_pkg;
   typedef enum logic {
      FR_EVEN = 1'b0,
      FR_ODD  = 1'b1
   } frame_par_e;

   function automatic logic par_hit(input logic want, input logic cur);
      return frame_par_e'(want) == frame_par_e'(cur);
   endfunction
endpackage

// File: rtl/frame_down_ctr.sv
module frame_down_ctr #(
   parameter int IVL_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IVL_W-1:0] ivl_i,
   output logic [IVL_W-1:0] remain_o,
   output logic             zero_o
);
   logic [IVL_W-1:0] cnt_q;

   assign zero_o   = (cnt_q == '0);
   assign remain_o = cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= ivl_i;
      end else if (zero_o) begin
         cnt_q <= ivl_i;
      end else begin
         cnt_q <= cnt_q - 1'b1;
      end
   end
endmodule

// File: rtl/frame_num_ctr.sv
module frame_num_ctr #(
   parameter int FNUM_W  = 14,
   parameter int WRAP_AT = (2 ** FNUM_W) - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sof_i,
   input  logic              clr_req_i,
   output logic [FNUM_W-1:0] frnum_o,
   output logic              pend_o
);
   localparam logic [FNUM_W-1:0] WRAP_V = FNUM_W'(WRAP_AT);
   localparam bit FULL_RANGE = (WRAP_AT == (2 ** FNUM_W) - 1);

   logic [FNUM_W-1:0] num_q;
   logic [FNUM_W-1:0] num_inc;
   logic              pend_q;

   generate
      if (FULL_RANGE) begin : g_natural
         assign num_inc = num_q + 1'b1;
      end else begin : g_compare
         assign num_inc = (num_q == WRAP_V) ? '0 : num_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         num_q  <= '0;
         pend_q <= 1'b0;
      end else if (sof_i) begin
         num_q  <= (pend_q || clr_req_i) ? '0 : num_inc;
         pend_q <= 1'b0;
      end else if (clr_req_i) begin
         pend_q <= 1'b1;
      end
   end

   assign frnum_o = num_q;
   assign pend_o  = pend_q;
endmodule

// File: rtl/frame_parity_match.sv
module frame_parity_match
   import usb_sof_pkg::*;
#(
   parameter int NUM_CH = 4
) (
   input  logic              lsb_i,
   input  logic [NUM_CH-1:0] odd_sel_i,
   output logic              odd_o,
   output logic [NUM_CH-1:0] elig_o
);
   assign odd_o = lsb_i;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign elig_o[c] = par_hit(odd_sel_i[c], lsb_i);
   end
endmodule

// File: rtl/usb_sof_timer.sv
module usb_sof_timer #(
   parameter int IVL_W   = 16,
   parameter int FNUM_W  = 14,
   parameter int WRAP_AT = (2 ** FNUM_W) - 1,
   parameter int NUM_CH  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IVL_W-1:0]  interval_i,
   input  logic              frnum_clr_i,
   input  logic [NUM_CH-1:0] odd_sel_i,
   output logic [IVL_W-1:0]  remain_o,
   output logic [FNUM_W-1:0] frnum_o,
   output logic              odd_frame_o,
   output logic              sof_o,
   output logic [NUM_CH-1:0] chan_elig_o
);
   initial begin
      assert (IVL_W >= 2 && IVL_W <= 32) else $error("IVL_W out of range");
      assert (FNUM_W >= 2 && FNUM_W <= 30) else $error("FNUM_W out of range");
      assert (WRAP_AT >= 1 && WRAP_AT <= (2 ** FNUM_W) - 1)
         else $error("WRAP_AT does not fit FNUM_W");
      assert (NUM_CH >= 1) else $error("NUM_CH must be positive");
   end

   logic zero_w;
   logic clr_pend;

   frame_down_ctr #(.IVL_W(IVL_W)) u_down (
      .clk      (clk),
      .rst_n    (rst_n),
      .ivl_i    (interval_i),
      .remain_o (remain_o),
      .zero_o   (zero_w)
   );

   assign sof_o = zero_w;

   frame_num_ctr #(.FNUM_W(FNUM_W), .WRAP_AT(WRAP_AT)) u_num (
      .clk       (clk),
      .rst_n     (rst_n),
      .sof_i     (zero_w),
      .clr_req_i (frnum_clr_i),
      .frnum_o   (frnum_o),
      .pend_o    (clr_pend)
   );

   frame_parity_match #(.NUM_CH(NUM_CH)) u_par (
      .lsb_i     (frnum_o[0]),
      .odd_sel_i (odd_sel_i),
      .odd_o     (odd_frame_o),
      .elig_o    (chan_elig_o)
   );
endmodule

// File: rtl/usb_sof_timer_chk.sv
module usb_sof_timer_chk #(
   parameter int IVL_W   = 16,
   parameter int FNUM_W  = 14,
   parameter int WRAP_AT = (2 ** FNUM_W) - 1,
   parameter int NUM_CH  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [IVL_W-1:0]  interval_i,
   input logic              frnum_clr_i,
   input logic [NUM_CH-1:0] odd_sel_i,
   input logic [IVL_W-1:0]  remain_o,
   input logic [FNUM_W-1:0] frnum_o,
   input logic              odd_frame_o,
   input logic              sof_o,
   input logic [NUM_CH-1:0] chan_elig_o,
   input logic              clr_pend
);
   localparam logic [FNUM_W-1:0] WRAP_V = FNUM_W'(WRAP_AT);

   // R2: countdown step
   p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (remain_o != '0) |=> (remain_o == $past(remain_o) - 1'b1));

   // R3 and R8: reload takes the interval present at the reload edge
   p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
      sof_o |=> (remain_o == $past(interval_i)));

   // R4: strobe lasts one cycle when the interval is non-zero
   p_sof_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (sof_o && interval_i != '0) |=> !sof_o);

   // R5: frame number holds between start-of-frames
   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !sof_o |=> $stable(frnum_o));

   // R5: increment on a plain start-of-frame
   p_inc_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sof_o && !clr_pend && !frnum_clr_i && frnum_o != WRAP_V)
      |=> (frnum_o == FNUM_W'($past(frnum_o) + 1'b1)));

   // R6: wrap back to zero
   p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (sof_o && frnum_o == WRAP_V) |=> (frnum_o == '0));

   // R7: a pending or same-cycle restart request forces zero
   p_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (sof_o && (clr_pend || frnum_clr_i)) |=> (frnum_o == '0));

   // R9: parity flag and per-channel eligibility
   p_odd_r9: assert property (@(posedge clk) disable iff (!rst_n)
      odd_frame_o == frnum_o[0]);

   for (genvar c = 0; c < NUM_CH; c++) begin : g_elig
      p_elig_r9: assert property (@(posedge clk) disable iff (!rst_n)
         chan_elig_o[c] == (odd_sel_i[c] == frnum_o[0]));
   end
endmodule

bind usb_sof_timer usb_sof_timer_chk #(
   .IVL_W(IVL_W), .FNUM_W(FNUM_W), .WRAP_AT(WRAP_AT), .NUM_CH(NUM_CH)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .interval_i  (interval_i),
   .frnum_clr_i (frnum_clr_i),
   .odd_sel_i   (odd_sel_i),
   .remain_o    (remain_o),
   .frnum_o     (frnum_o),
   .odd_frame_o (odd_frame_o),
   .sof_o       (sof_o),
   .chan_elig_o (chan_elig_o),
   .clr_pend    (clr_pend)
);

// File: tb/sim_usb_sof_timer.sv
module sim_usb_sof_timer;
   localparam int CLK_T  = 10;
   localparam int IVL_W  = 16;
   localparam int FNUM_W = 14;
   localparam int NUM_CH = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [IVL_W-1:0]  interval_i = '0;
   logic              frnum_clr_i = 1'b0;
   logic [NUM_CH-1:0] odd_sel_i = '0;
   logic [IVL_W-1:0]  remain_o;
   logic [FNUM_W-1:0] frnum_o;
   logic              odd_frame_o;
   logic              sof_o;
   logic [NUM_CH-1:0] chan_elig_o;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   always #(CLK_T / 2) clk = ~clk;

   usb_sof_timer #(.IVL_W(IVL_W), .FNUM_W(FNUM_W), .NUM_CH(NUM_CH)) u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .interval_i  (interval_i),
      .frnum_clr_i (frnum_clr_i),
      .odd_sel_i   (odd_sel_i),
      .remain_o    (remain_o),
      .frnum_o     (frnum_o),
      .odd_frame_o (odd_frame_o),
      .sof_o       (sof_o),
      .chan_elig_o (chan_elig_o)
   );

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic [IVL_W-1:0] ivl);
      interval_i = ivl;
      rst_n = 1'b0;
      tick();
      tick();
      rst_n = 1'b1;
   endtask

   task automatic t_reset();
      odd_sel_i = 4'b1010;
      do_reset(16'd5);
      chk("R1 remain", remain_o, 32'd5);
      chk("R1 frnum", frnum_o, 32'd0);
      chk("R1 sof", sof_o, 32'd0);
      chk("R9 odd even-frame", odd_frame_o, 32'd0);
      chk("R9 elig even-frame", chan_elig_o, 32'h5);
   endtask

   task automatic t_countdown();
      for (int k = 4; k >= 0; k--) begin
         tick();
         chk("R2 step", remain_o, k);
         chk("R4 sof level", sof_o, (k == 0) ? 32'd1 : 32'd0);
         chk("R5 hold", frnum_o, 32'd0);
      end
      tick();
      chk("R3 reload", remain_o, 32'd5);
      chk("R5 inc", frnum_o, 32'd1);
      chk("R4 single pulse", sof_o, 32'd0);
      chk("R9 odd odd-frame", odd_frame_o, 32'd1);
      chk("R9 elig odd-frame", chan_elig_o, 32'hA);
   endtask

   task automatic t_ivl_change();
      tick();
      tick();
      chk("R8 before change", remain_o, 32'd3);
      interval_i = 16'd9;
      for (int k = 2; k >= 0; k--) begin
         tick();
         chk("R8 countdown kept", remain_o, k);
      end
      chk("R5 hold mid-frame", frnum_o, 32'd1);
      tick();
      chk("R8 new interval at reload", remain_o, 32'd9);
      chk("R5 inc second", frnum_o, 32'd2);
   endtask

   task automatic t_clear();
      tick();
      frnum_clr_i = 1'b1;
      tick();
      frnum_clr_i = 1'b0;
      chk("R7 unchanged before sof", frnum_o, 32'd2);
      for (int k = 6; k >= 0; k--) tick();
      chk("R7 sof reached", sof_o, 32'd1);
      chk("R7 still unchanged", frnum_o, 32'd2);
      tick();
      chk("R7 zero after sof", frnum_o, 32'd0);
      for (int k = 0; k < 10; k++) tick();
      chk("R7 request used once", frnum_o, 32'd1);
      chk("R3 full frame length", remain_o, 32'd9);
   endtask

   task automatic t_clear_at_sof();
      interval_i = 16'd1;
      for (int k = 0; k < 9; k++) tick();
      chk("R4 sof before same-cycle clear", sof_o, 32'd1);
      frnum_clr_i = 1'b1;
      tick();
      frnum_clr_i = 1'b0;
      chk("R7 same-cycle clear", frnum_o, 32'd0);
      chk("R3 short interval reload", remain_o, 32'd1);
      tick();
      tick();
      chk("R3 two-clock frame", remain_o, 32'd1);
      chk("R5 inc after short frame", frnum_o, 32'd1);
   endtask

   task automatic t_wrap();
      int bad = 0;
      do_reset(16'd0);
      chk("R4 zero interval sof", sof_o, 32'd1);
      for (int k = 1; k <= 16383; k++) begin
         tick();
         if (sof_o !== 1'b1 || frnum_o !== FNUM_W'(k)) bad++;
      end
      chk("R4 R5 every-cycle sof run", bad, 32'd0);
      chk("R6 at top", frnum_o, 32'h3FFF);
      tick();
      chk("R6 wrapped", frnum_o, 32'd0);
      chk("R9 even after wrap", odd_frame_o, 32'd0);
   endtask

   initial begin
      #(CLK_T * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_countdown();
      t_ivl_change();
      t_clear();
      t_clear_at_sof();
      t_wrap();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule